// File: doc/BRIEF.md
# Minute-Resolution Watchdog Timer

This block is a watchdog that counts down in whole minutes. Software loads an 8-bit count from 1 to 255. An internal prescaler divides the system clock into one-minute ticks, and each tick takes one off the count. When the count runs out, the block sets a sticky timeout flag. It can then raise an interrupt, and it can make a status LED blink. A write of zero parks the timer without a timeout.

A rising edge on the keyboard or mouse interrupt input counts as a kick. A kick reloads the most recently written count and starts a fresh minute. Kicks are ignored whenever the count is already zero, so neither a stopped timer nor an expired one can be revived this way.

The block has a small register port with four byte addresses:

| Address | Contents |
|---|---|
| 0 | count |
| 1 | control byte |
| 2 | status byte |
| 3 | second view of the status byte |

Reads are combinational and writes take effect on the clock edge. The minute length and the blink rate are parameters, so a simulation can use short periods.

Top module: `wdog_minute_top`

## Requirements
- R1: While the count is non-zero it drops by exactly one every MINUTE_CYC clock cycles. The first drop comes MINUTE_CYC cycles after the count is loaded.
- R2: Writing a non-zero byte to address 0 loads that value as the count and restarts the minute prescaler. Reading address 0 returns the remaining count.
- R3: Writing zero to address 0 stops the timer. The count reads 0 afterwards, the prescaler stops, and the timeout flag is not set.
- R4: A rising edge on kbd_irq_i or ms_irq_i while the count is non-zero reloads the last non-zero value written to address 0 and restarts the minute. While the count is zero such an edge has no effect: the count stays 0 and the flag is unchanged.
- R5: When a minute tick takes the count from 1 to 0, the timeout flag is set. The flag reads as bit 0 at both address 2 and address 3. Bits 7..1 at those addresses always read 0.
- R6: wdt_irq_o is high exactly when the timeout flag is set and bit 1 (interrupt enable) of the control byte at address 1 is 1.
- R7: While the flag is set and bit 3 (blink enable) of the control byte is 1, led_o starts low and inverts every MINUTE_CYC/BLINK_DIV cycles. Otherwise led_o is 0.
- R8: Writing address 2 or 3 with bit 0 equal to 0 clears the flag, which drops the interrupt and stops the blinking. Writing bit 0 as 1 leaves the flag unchanged.
- R9: The control byte reads back the last value written to address 1. After reset, the count, the control byte, the flag, wdt_irq_o and led_o are all 0.
- R10: A count write in the same cycle as a kick wins over the kick. A timeout in the same cycle as a flag-clear write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_wr_i | input | 1 | Register write strobe |
| acc_addr_i | input | 2 | Register address: 0 count, 1 control, 2 and 3 status |
| acc_wdata_i | input | 8 | Register write data |
| acc_rdata_o | output | 8 | Read data for acc_addr_i |
| kbd_irq_i | input | 1 | Keyboard interrupt, used as a kick on its rising edge |
| ms_irq_i | input | 1 | Mouse interrupt, used as a kick on its rising edge |
| wdt_irq_o | output | 1 | Timeout interrupt |
| led_o | output | 1 | Status LED, blinking after a timeout |

## Verification
The assertions assume that the kick inputs are synchronous to clk and that a register write presents stable address and data in its strobe cycle. They also assume that the count written is a plain byte, so the only special value is zero. The stimulus drives every input on the falling edge, pulses each kick for whole cycles, and deliberately lines up a count write with a kick edge and a flag clear with the expiry edge. That way, both priority rules are exercised through legal traffic only.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int IRQ_EN_BIT = 1;
  localparam int BLINK_EN_BIT = 3;
  localparam int FLAG_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    ADR_COUNT    = 2'd0,
    ADR_CTRL     = 2'd1,
    ADR_STAT     = 2'd2,
    ADR_STAT_ALT = 2'd3
  } wd_addr_e;
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter longint unsigned PERIOD = 64'd60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (PERIOD > 64'd1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 64'd1);

  logic [CW-1:0] ctr_q, ctr_d;
  logic ctr_en, at_last;

  assign at_last = (ctr_q == LAST);
  assign tick_o  = run_i & ~restart_i & at_last;
  assign ctr_en  = run_i | restart_i | (ctr_q != '0);

  always_comb begin
    if (!run_i || restart_i) ctr_d = '0;
    else if (at_last)        ctr_d = '0;
    else                     ctr_d = ctr_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctr_q <= '0;
    else if (ctr_en) ctr_q <= ctr_d;
  end

  // an idle divider sits at zero one cycle after it was stopped
  assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !restart_i) |=> (ctr_q == '0));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              kick_i,
  input  logic              tick_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              flag_o,
  output logic              restart_o
);
  logic [DATA_W-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic flag_q, flag_d;
  logic load_wr, kick_ok, expire, cnt_en, rel_en, flag_en;

  assign load_wr  = wr_i & (wdata_i != '0);
  assign kick_ok  = kick_i & (cnt_q != '0) & ~wr_i;
  assign expire   = ~wr_i & ~kick_ok & tick_i & (cnt_q == DATA_W'(1));
  assign restart_o = load_wr | kick_ok;

  assign cnt_en  = wr_i | kick_ok | (tick_i & (cnt_q != '0));
  assign rel_en  = load_wr;
  assign flag_en = expire | clr_i;

  always_comb begin
    if (wr_i)         cnt_d = wdata_i;
    else if (kick_ok) cnt_d = rel_q;
    else              cnt_d = cnt_q - DATA_W'(1);
    rel_d  = wdata_i;
    flag_d = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rel_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (rel_en)  rel_q  <= rel_d;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !wr_i && !kick_i) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - DATA_W'(1)));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt_q == $past(wdata_i)));
  assert_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i == '0 && !clr_i) |=> (cnt_q == '0 && flag_q == $past(flag_q)));
  assert_kick_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && cnt_q == '0 && !wr_i) |=> (cnt_q == '0));
  assert_reload_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (rel_q != '0));
  assert_expire_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == DATA_W'(1) && !wr_i && !kick_i) |=> flag_q);
endmodule

// File: rtl/wdog_led.sv
module wdog_led (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic blink_tick_i,
  output logic led_o
);
  logic led_q, led_d, led_en;

  assign led_en = ~active_i | blink_tick_i;

  always_comb begin
    if (!active_i) led_d = 1'b0;
    else           led_d = ~led_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= 1'b0;
    else if (led_en) led_q <= led_d;
  end

  assign led_o = led_q;

  assert_led_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i |=> !led_q);
  assert_led_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !blink_tick_i) |=> $stable(led_q));
endmodule

// File: rtl/wdog_minute_top.sv
module wdog_minute_top
  import wdog_pkg::*;
#(
  parameter longint unsigned MINUTE_CYC = 64'd6_000_000_000,
  parameter int unsigned     BLINK_DIV  = 120
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic              kbd_irq_i,
  input  logic              ms_irq_i,
  output logic              wdt_irq_o,
  output logic              led_o
);
  localparam longint unsigned BLINK_CYC = MINUTE_CYC / longint'(BLINK_DIV);

  // reset: asserted at once, released two edges later
  logic [1:0] rs_q;
  logic rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  // register decode
  wd_addr_e adr;
  logic wr_cnt, wr_ctrl, wr_stat, clr_flag;
  assign adr      = wd_addr_e'(acc_addr_i);
  assign wr_cnt   = acc_wr_i & (adr == ADR_COUNT);
  assign wr_ctrl  = acc_wr_i & (adr == ADR_CTRL);
  assign wr_stat  = acc_wr_i & ((adr == ADR_STAT) | (adr == ADR_STAT_ALT));
  assign clr_flag = wr_stat & ~acc_wdata_i[FLAG_BIT];

  logic [DATA_W-1:0] ctrl_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= acc_wdata_i;
  end

  // kick edge detection
  logic kbd_q, ms_q, kick;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      kbd_q <= 1'b0;
      ms_q  <= 1'b0;
    end else begin
      kbd_q <= kbd_irq_i;
      ms_q  <= ms_irq_i;
    end
  end
  assign kick = (kbd_irq_i & ~kbd_q) | (ms_irq_i & ~ms_q);

  logic [DATA_W-1:0] cnt;
  logic flag, restart, min_tick, blink_tick, blink_on;

  wdog_tick_gen #(.PERIOD(MINUTE_CYC)) u_minute (
    .clk(clk), .rst_n(rst_int_n), .run_i(cnt != '0), .restart_i(restart),
    .tick_o(min_tick));

  wdog_counter u_count (
    .clk(clk), .rst_n(rst_int_n), .wr_i(wr_cnt), .wdata_i(acc_wdata_i),
    .kick_i(kick), .tick_i(min_tick), .clr_i(clr_flag),
    .cnt_o(cnt), .flag_o(flag), .restart_o(restart));

  assign blink_on = flag & ctrl_q[BLINK_EN_BIT];

  wdog_tick_gen #(.PERIOD(BLINK_CYC)) u_blink (
    .clk(clk), .rst_n(rst_int_n), .run_i(blink_on), .restart_i(1'b0),
    .tick_o(blink_tick));

  wdog_led u_led (
    .clk(clk), .rst_n(rst_int_n), .active_i(blink_on),
    .blink_tick_i(blink_tick), .led_o(led_o));

  assign wdt_irq_o = flag & ctrl_q[IRQ_EN_BIT];

  always_comb begin
    acc_rdata_o = '0;
    case (adr)
      ADR_COUNT: acc_rdata_o = cnt;
      ADR_CTRL:  acc_rdata_o = ctrl_q;
      default:   acc_rdata_o[FLAG_BIT] = flag;
    endcase
  end

  // a clear that cannot collide with an expiry always drops the interrupt
  assert_clear_irq_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_flag && cnt != DATA_W'(1)) |=> !wdt_irq_o);
  assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(wdt_irq_o) |-> ctrl_q[IRQ_EN_BIT]);
  assert_stat_upper_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (adr == ADR_STAT || adr == ADR_STAT_ALT) |-> (acc_rdata_o[DATA_W-1:1] == '0));
endmodule

// File: tb/test_wdog_minute_top.sv
module test_wdog_minute_top;
  localparam int N  = 40;
  localparam int BD = 8;
  localparam int B  = N / BD;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, acc_wr, kbd, ms;
  logic [1:0] acc_addr;
  logic [7:0] acc_wdata, rdata;
  logic irq, led;

  wdog_minute_top #(.MINUTE_CYC(64'(N)), .BLINK_DIV(BD)) i_wdog_minute_top (
    .clk(clk), .rst_n(rst_n), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(rdata), .kbd_irq_i(kbd),
    .ms_irq_i(ms), .wdt_irq_o(irq), .led_o(led));

  int errs = 0, checks = 0;
  bit cmp_on = 0;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_rel, m_pre, m_c0, m_bc;
  bit m_flag, m_led, m_kp, m_mp, m_rs1, m_rs2;
  bit t_kick, t_wc, t_kok, t_ld, t_tk, t_ex, t_act, t_clr;

  function automatic int mread(input logic [1:0] a);
    if (a == 2'd0) return m_cnt;
    if (a == 2'd1) return m_c0;
    return int'(m_flag);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || !m_rs2) begin
      m_cnt = 0; m_rel = 0; m_pre = 0; m_c0 = 0; m_bc = 0;
      m_flag = 0; m_led = 0; m_kp = 0; m_mp = 0;
    end else begin
      t_kick = (kbd && !m_kp) || (ms && !m_mp);
      t_wc   = acc_wr && acc_addr == 2'd0;
      t_kok  = t_kick && m_cnt != 0 && !t_wc;
      t_ld   = (t_wc && acc_wdata != 0) || t_kok;
      t_tk   = m_cnt != 0 && !t_ld && m_pre == N - 1;
      t_ex   = !t_wc && !t_kok && t_tk && m_cnt == 1;
      t_clr  = acc_wr && acc_addr[1] && !acc_wdata[0];
      t_act  = m_flag && m_c0[3];
      // blink
      if (!t_act) begin m_bc = 0; m_led = 0; end
      else if (m_bc == B - 1) begin m_bc = 0; m_led = !m_led; end
      else m_bc++;
      // prescaler
      if (m_cnt == 0 || t_ld || m_pre == N - 1) m_pre = 0;
      else m_pre++;
      // count
      if (t_wc) begin
        if (acc_wdata != 0) m_rel = acc_wdata;
        m_cnt = acc_wdata;
      end else if (t_kok) m_cnt = m_rel;
      else if (t_tk) m_cnt--;
      if (t_ex) m_flag = 1;
      else if (t_clr) m_flag = 0;
      if (acc_wr && acc_addr == 2'd1) m_c0 = acc_wdata;
      m_kp = kbd; m_mp = ms;
    end
    if (!rst_n) begin m_rs1 = 0; m_rs2 = 0; end
    else begin m_rs2 = m_rs1; m_rs1 = 1; end
  end

  // cycle-by-cycle comparison
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      case (acc_addr)
        2'd0: chk("R2 count read", rdata, mread(acc_addr));
        2'd1: chk("R9 control read", rdata, mread(acc_addr));
        default: chk("R5 status read", rdata, mread(acc_addr));
      endcase
      chk("R6 irq", irq, int'(m_flag && m_c0[1]));
      chk("R7 led", led, int'(m_led));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit kb = 0);
    @(negedge clk);
    acc_wr = 1; acc_addr = a; acc_wdata = d; kbd = kb;
    @(negedge clk);
    acc_wr = 0; kbd = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    acc_addr = a;
    #1 v = rdata;
  endtask

  task automatic pulse_kbd(input bit mouse);
    @(negedge clk);
    if (mouse) ms = 1; else kbd = 1;
    @(negedge clk);
    ms = 0; kbd = 0;
  endtask

  initial begin
    #(10 * 100000);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int v, tog;
    logic prev;
    rst_n = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0; kbd = 0; ms = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp_on = 1;
    // R9 reset state
    rd(2'd0, v); chk("R9 reset count", v, 0);
    rd(2'd1, v); chk("R9 reset control", v, 0);
    chk("R9 reset irq", irq, 0);
    chk("R9 reset led", led, 0);
    wr(2'd1, 8'h0A);
    rd(2'd1, v); chk("R9 control readback", v, 8'h0A);
    // R2 / R1 countdown
    wr(2'd0, 8'd3);
    rd(2'd0, v); chk("R2 load", v, 3);
    repeat (20) @(negedge clk);
    rd(2'd0, v); chk("R1 before first minute", v, 3);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk("R1 after one minute", v, 2);
    // R4 kick reload
    pulse_kbd(0);
    repeat (5) @(negedge clk);
    rd(2'd0, v); chk("R4 kick reloads", v, 3);
    // R5 expiry
    repeat (130) @(negedge clk);
    rd(2'd0, v); chk("R5 count at zero", v, 0);
    rd(2'd3, v); chk("R5 flag at alias", v, 1);
    rd(2'd2, v); chk("R5 flag at status", v, 1);
    chk("R6 irq after timeout", irq, 1);
    // R7 blinking
    tog = 0; prev = led;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (led !== prev) tog++;
      prev = led;
    end
    chk("R7 led toggles", int'(tog >= 3), 1);
    // R4 kick ignored while zero
    pulse_kbd(1);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R4 kick ignored at zero", v, 0);
    rd(2'd2, v); chk("R4 flag kept", v, 1);
    // R8 clear rules
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R8 write one keeps flag", v, 1);
    wr(2'd3, 8'hFE);
    rd(2'd2, v); chk("R8 clear via alias", v, 0);
    chk("R8 irq dropped", irq, 0);
    repeat (2) @(negedge clk);
    chk("R8 led dark", led, 0);
    // R3 stop by zero write
    wr(2'd0, 8'd5);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'd0);
    repeat (300) @(negedge clk);
    rd(2'd0, v); chk("R3 stopped count", v, 0);
    rd(2'd2, v); chk("R3 no timeout", v, 0);
    // R10 write beats kick; expiry beats clear
    wr(2'd0, 8'd7);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'd2, 1);
    repeat (79) @(negedge clk);
    acc_wr = 1; acc_addr = 2'd3; acc_wdata = 8'h00;
    @(negedge clk);
    acc_wr = 0;
    rd(2'd2, v); chk("R10 expiry beats clear", v, 1);
    rd(2'd0, v); chk("R10 write beat kick then expired", v, 0);
    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule